// File: doc/BRIEF.md
# Serial Port FIFO Status Unit

This block holds the two data queues of a synchronous serial port, one for transmit and one for receive, each 16 words deep. Bus writes fill the transmit queue and the serial shifter drains it. The shifter fills the receive queue and bus reads drain it. Both queues are first-word-fall-through: the head word is always visible on the read side.

Around the queues the block keeps a 32-bit status word at register offset 0x08. The word reports the fill levels in two deliberately lossy 4-bit encodings, a sticky receive-overrun flag, two threshold-based service requests, the shifter's busy state and two queue flags. An interrupt line combines the overrun flag and the service requests. Software clears the overrun flag by writing 1 to its bit. Every other bit is read-only.

The status word is registered. It reads 0 in reset and follows the queue state one clock after each change.

Top module: `serport_fifo_status`

## Requirements
- R1: While reset is asserted, the register read data at offset 0x08 is 0x0000_0000 and `irq` is 0. Both queues start empty.
- R2: A bus write (`tx_wr_en`) enters the transmit queue unless the queue holds 16 words and no shifter pop happens in the same cycle, in which case the write is discarded. `sh_tx_data` shows the oldest word, and `sh_tx_pop` removes it, so words leave in write order. A pop of an empty queue has no effect.
- R3: A shifter push (`sh_rx_push`) enters the receive queue unless the queue is full. `rx_rd_data` shows the oldest word, and `rx_rd_en` removes it, so words leave in arrival order. A read of an empty queue has no effect.
- R4: `reg_rd_data` shows the status word when `reg_addr` is 0x08 and shows 0 for any other address. The status word reflects the queue state one clock after that state changes.
- R5: Status bits 15:12 hold (receive word count − 1) modulo 16. An empty queue and a full queue both read 0xF.
- R6: Status bits 11:8 hold the transmit word count modulo 16. An empty queue and a full queue both read 0x0.
- R7: A push into a full receive queue with no bus read in the same cycle is dropped and sets status bit 7. A push and a read in the same cycle on a full queue are both accepted, and bit 7 is not set.
- R8: Bit 7 stays set until a register write to 0x08 with data bit 7 = 1. Writing 0 to that bit, or writing to another address, leaves it unchanged. If a drop and a clear happen in the same cycle, the bit stays set.
- R9: Status bit 6 is 1 when `en` = 1, the receive queue is not empty, and (count − 1) ≥ `rx_thresh`. Otherwise it is 0.
- R10: Status bit 5 is 1 when `en` = 1 and the transmit count ≤ `tx_thresh`. Otherwise it is 0.
- R11: Status bit 4 mirrors `busy`, bit 3 is 1 when the receive queue is not empty, and bit 2 is 1 when the transmit queue is not full.
- R12: Bits 31:16 and 1:0 always read 0. A register write changes nothing except the clearing of bit 7.
- R13: `irq` is the OR of status bits 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; gates the service requests |
| busy | input | 1 | Shifter busy flag |
| tx_thresh | input | 4 | Transmit service threshold |
| rx_thresh | input | 4 | Receive service threshold |
| tx_wr_en | input | 1 | Bus write into the transmit queue |
| tx_wr_data | input | DATA_W | Bus write data |
| rx_rd_en | input | 1 | Bus read (pop) from the receive queue |
| rx_rd_data | output | DATA_W | Oldest receive word |
| sh_tx_pop | input | 1 | Shifter takes a transmit word |
| sh_tx_data | output | DATA_W | Oldest transmit word |
| sh_rx_push | input | 1 | Shifter delivers a received word |
| sh_rx_data | input | DATA_W | Received word |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are those at a full receive queue: a push in the same cycle as a bus read, and a drop in the same cycle as a software clear of the overrun flag. In both cases a full queue must coincide with two other events in one cycle. The bench fills the queue with sixteen shifter pushes and then drives both strobes together on a single falling edge.

The overrun case is then drained word by word, which confirms that the dropped word never appears. A bench model of both counts predicts every encoded level, including the ambiguous 0xF and 0x0 readings at the empty and full extremes.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int          LVL_W    = 4;
  localparam logic [31:0] STAT_OFS = 32'h0000_0008;
  localparam int          OVR_BIT  = 7;

  typedef struct packed {
    logic [15:0]      rsvd_hi;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
    logic             ovr;
    logic             rx_req;
    logic             tx_req;
    logic             busy;
    logic             rx_ne;
    logic             tx_nf;
    logic [1:0]       rsvd_lo;
  } status_t;
endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              drop
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_n;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              pop_ok, push_ok;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == FULL_CNT);
  assign pop_ok    = pop && !empty;
  assign push_ok   = push && (!full || pop_ok);
  assign drop      = push && full && !pop_ok;
  assign count     = cnt_q;
  assign head_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_n = wr_ptr_q;
    rd_ptr_n = rd_ptr_q;
    cnt_n    = cnt_q;
    if (push_ok) wr_ptr_n = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop_ok)  rd_ptr_n = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + PTR_W'(1);
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_n = cnt_q + CNT_W'(1);
      2'b01:   cnt_n = cnt_q - CNT_W'(1);
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  // R2, R3: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R2, R3: idle cycle leaves the count alone
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(cnt_q));
  // R7: a dropped word leaves the queue full
  a_r7_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> full);
endmodule

// File: rtl/serport_ovr.sv
module serport_ovr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              ovr
);
  import serport_pkg::*;

  logic clr_req;
  logic ovr_q, ovr_n;

  assign clr_req = reg_wr && (reg_addr == ADDR_W'(STAT_OFS)) && reg_wdata[OVR_BIT];

  always_comb begin
    ovr_n = ovr_q;
    if (drop)         ovr_n = 1'b1;
    else if (clr_req) ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_n;
  end

  assign ovr = ovr_q;

  // R7: a drop always leaves the flag set
  a_r7_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_q);
  // R8: flag stays set without a clear request
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_req) |=> ovr_q);
  // R8: a clear with no drop empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !drop) |=> !ovr_q);
endmodule

// File: rtl/serport_stat.sv
module serport_stat #(
  parameter  int CNT_W  = 5,
  parameter  int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              busy,
  input  logic [3:0]        tx_thresh,
  input  logic [3:0]        rx_thresh,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              ovr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic [31:0]       reg_rd_data,
  output logic              irq
);
  import serport_pkg::*;

  status_t          stat_q, stat_n;
  logic [CNT_W-1:0] rx_m1;
  logic             rx_req, tx_req;

  assign rx_m1  = rx_cnt - CNT_W'(1);
  assign rx_req = en && !rx_empty && (rx_m1 >= CNT_W'(rx_thresh));
  assign tx_req = en && (tx_cnt <= CNT_W'(tx_thresh));

  always_comb begin
    stat_n        = '0;
    stat_n.rx_lvl = rx_m1[LVL_W-1:0];
    stat_n.tx_lvl = tx_cnt[LVL_W-1:0];
    stat_n.ovr    = ovr;
    stat_n.rx_req = rx_req;
    stat_n.tx_req = tx_req;
    stat_n.busy   = busy;
    stat_n.rx_ne  = !rx_empty;
    stat_n.tx_nf  = !tx_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  assign reg_rd_data = (reg_addr == ADDR_W'(STAT_OFS)) ? stat_q : '0;
  assign irq         = stat_q.ovr | stat_q.rx_req | stat_q.tx_req;

  // R12: reserved fields stay zero
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q.rsvd_hi == '0) && (stat_q.rsvd_lo == '0));
  // R9, R10: disabled port raises no service request
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!stat_q.rx_req && !stat_q.tx_req));
  // R11: receive not-empty flag and level encoding agree
  a_r11_ne_level: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q.rx_ne == 1'b0) |-> (stat_q.rx_lvl == '0 || stat_q.rx_lvl == '1));
endmodule

// File: rtl/serport_fifo_status.sv
module serport_fifo_status #(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 8,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              busy,
  input  logic [3:0]        tx_thresh,
  input  logic [3:0]        rx_thresh,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data,
  input  logic              sh_tx_pop,
  output logic [DATA_W-1:0] sh_tx_data,
  input  logic              sh_rx_push,
  input  logic [DATA_W-1:0] sh_rx_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, tx_drop;
  logic             rx_full, rx_empty, rx_drop;
  logic             ovr;

  serport_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
    .clk, .rst_n,
    .push(tx_wr_en), .push_data(tx_wr_data), .pop(sh_tx_pop),
    .head_data(sh_tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty), .drop(tx_drop)
  );

  serport_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
    .clk, .rst_n,
    .push(sh_rx_push), .push_data(sh_rx_data), .pop(rx_rd_en),
    .head_data(rx_rd_data), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  serport_ovr #(.ADDR_W(ADDR_W)) u_ovr (
    .clk, .rst_n, .drop(rx_drop),
    .reg_wr, .reg_addr, .reg_wdata, .ovr
  );

  serport_stat #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_stat (
    .clk, .rst_n, .en, .busy, .tx_thresh, .rx_thresh,
    .tx_cnt, .rx_cnt, .tx_full, .rx_empty, .ovr,
    .reg_addr, .reg_rd_data, .irq
  );

  // R2: a full transmit queue ignores an unpaired write
  a_r2_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop && !sh_tx_pop) |=> tx_full);
  // R3: a read of the empty receive queue leaves it empty
  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && rx_rd_en && !sh_rx_push) |=> rx_empty);
endmodule

// File: tb/serport_fifo_status_bench.sv
module serport_fifo_status_bench;
  logic        clk = 1'b0;
  logic        rst_n, en, busy;
  logic [3:0]  tx_thresh, rx_thresh;
  logic        tx_wr_en, rx_rd_en, sh_tx_pop, sh_rx_push, reg_wr;
  logic [15:0] tx_wr_data, sh_rx_data, rx_rd_data, sh_tx_data;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rd_data;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  int m_tx = 0, m_rx = 0;
  bit m_ovr = 0;

  always #4 clk = ~clk;

  serport_fifo_status u_serport_fifo_status (
    .clk, .rst_n, .en, .busy, .tx_thresh, .rx_thresh,
    .tx_wr_en, .tx_wr_data, .rx_rd_en, .rx_rd_data,
    .sh_tx_pop, .sh_tx_data, .sh_rx_push, .sh_rx_data,
    .reg_addr, .reg_wr, .reg_wdata, .reg_rd_data, .irq
  );

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = '0;
    v[15:12] = 4'((m_rx + 15) % 16);
    v[11:8]  = 4'(m_tx % 16);
    v[7]     = m_ovr;
    v[6]     = en && (m_rx > 0) && ((m_rx - 1) >= int'(rx_thresh));
    v[5]     = en && (m_tx <= int'(tx_thresh));
    v[4]     = busy;
    v[3]     = (m_rx > 0);
    v[2]     = (m_tx < 16);
    return v;
  endfunction

  task automatic chk_stat(input string tag);
    logic [31:0] e;
    reg_addr = 8'h08;
    tick;
    e = exp_stat();
    chk(tag, reg_rd_data, e);
    chk({tag, " R13 irq"}, {31'd0, irq}, {31'd0, e[7] | e[6] | e[5]});
  endtask

  task automatic bus_wr(input logic [15:0] d);
    tx_wr_en = 1; tx_wr_data = d; tick; tx_wr_en = 0;
    if (m_tx < 16) m_tx++;
  endtask

  task automatic sh_pop(input logic [15:0] e, input string tag);
    chk(tag, {16'd0, sh_tx_data}, {16'd0, e});
    sh_tx_pop = 1; tick; sh_tx_pop = 0;
    if (m_tx > 0) m_tx--;
  endtask

  task automatic sh_push(input logic [15:0] d);
    sh_rx_push = 1; sh_rx_data = d; tick; sh_rx_push = 0;
    if (m_rx < 16) m_rx++; else m_ovr = 1;
  endtask

  task automatic bus_rd(input logic [15:0] e, input string tag);
    chk(tag, {16'd0, rx_rd_data}, {16'd0, e});
    rx_rd_en = 1; tick; rx_rd_en = 0;
    if (m_rx > 0) m_rx--;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick; reg_wr = 0;
    if (a == 8'h08 && d[7]) m_ovr = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; en = 0; busy = 0; tx_thresh = 0; rx_thresh = 0;
    tx_wr_en = 0; rx_rd_en = 0; sh_tx_pop = 0; sh_rx_push = 0; reg_wr = 0;
    tx_wr_data = 0; sh_rx_data = 0; reg_addr = 8'h08; reg_wdata = 0;
    repeat (3) tick;
    chk("R1 reset status", reg_rd_data, 32'h0);
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
    rst_n = 1;
    chk_stat("R5 R6 idle levels");
  endtask

  task automatic t_tx_order;
    for (int i = 0; i < 3; i++) bus_wr(16'hA000 + 16'(i));
    chk_stat("R6 three tx words");
    for (int i = 0; i < 3; i++) sh_pop(16'hA000 + 16'(i), "R2 tx order");
    chk_stat("R6 tx drained");
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < 16; i++) bus_wr(16'hB000 + 16'(i));
    chk_stat("R6 tx full reads 0 and R11 not-full clear");
    bus_wr(16'hDEAD);
    chk_stat("R2 write to full tx ignored");
    for (int i = 0; i < 16; i++) sh_pop(16'hB000 + 16'(i), "R2 tx full order");
    sh_tx_pop = 1; tick; sh_tx_pop = 0;
    chk_stat("R2 pop of empty tx ignored");
  endtask

  task automatic t_rx_overrun;
    sh_push(16'hC000);
    chk_stat("R5 one rx word reads 0");
    for (int i = 1; i < 16; i++) sh_push(16'hC000 + 16'(i));
    chk_stat("R5 rx full reads F");
    chk("R3 rx head", {16'd0, rx_rd_data}, 32'h0000C000);
    sh_rx_push = 1; sh_rx_data = 16'hC010; rx_rd_en = 1; tick;
    sh_rx_push = 0; rx_rd_en = 0;
    chk_stat("R7 push with read on full, no overrun");
    sh_push(16'hEEEE);
    sh_push(16'hEEEF);
    chk_stat("R7 overrun flagged");
    for (int i = 1; i <= 16; i++) bus_rd(16'hC000 + 16'(i), "R3 R7 rx order, dropped words absent");
    rx_rd_en = 1; tick; rx_rd_en = 0;
    chk_stat("R3 read of empty rx ignored, R8 flag kept");
    reg_write(8'h08, 32'h0000_0000);
    chk_stat("R8 writing 0 keeps flag");
    reg_write(8'h04, 32'h0000_0080);
    chk_stat("R8 other address keeps flag");
    reg_write(8'h08, 32'h0000_0080);
    chk_stat("R8 write 1 clears flag");
    for (int i = 0; i < 16; i++) sh_push(16'h1000 + 16'(i));
    sh_rx_push = 1; sh_rx_data = 16'h2222;
    reg_addr = 8'h08; reg_wdata = 32'h80; reg_wr = 1; tick;
    sh_rx_push = 0; reg_wr = 0; m_ovr = 1;
    chk_stat("R8 drop wins over clear");
    for (int i = 0; i < 16; i++) bus_rd(16'h1000 + 16'(i), "R3 rx refill order");
    reg_write(8'h08, 32'h80);
    chk_stat("R8 cleared after drain");
  endtask

  task automatic t_requests;
    en = 1; rx_thresh = 4'd2; tx_thresh = 4'd1;
    chk_stat("R10 empty tx requests");
    sh_push(16'h0001); sh_push(16'h0002);
    chk_stat("R9 rx level 1 below 2");
    sh_push(16'h0003);
    chk_stat("R9 rx level 2 at threshold");
    bus_wr(16'h0011);
    chk_stat("R10 tx count 1 at threshold");
    bus_wr(16'h0012);
    chk_stat("R10 tx count 2 above threshold");
    en = 0;
    chk_stat("R9 R10 disabled clears requests");
    busy = 1;
    chk_stat("R11 busy mirrored");
    reg_write(8'h08, 32'hFFFF_FFFF);
    chk_stat("R12 write all ones changes nothing else");
    reg_addr = 8'h0C; tick;
    chk("R4 other address reads 0", reg_rd_data, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_tx_order;
    t_tx_full;
    t_rx_overrun;
    t_requests;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule